// File: doc/BRIEF.md
# Word-to-Byte Unpacker with Cross-Clock Handshake

The block takes 32-bit words from a memory reader that runs in a fast clock domain and serves them, one byte per read strobe, to a consumer in a slow clock domain. A fast-side holding register captures each word when the reader strobes it in. It reverses the byte order and then offers the word across the clock boundary with a valid/acknowledge handshake. The handshake is a full four-phase exchange. The slow side raises acknowledge when it takes the word and keeps it high until it sees valid fall. The fast side raises valid again only once acknowledge has fallen. Because of this, the exchange is correct at any ratio between the two clocks. The nominal clocks are 100 MHz on the fast side and 1 MHz on the slow side.

The fast side runs a four-state machine.
- `F_REQUEST` asks for a word. A strobe moves it to `F_OFFER`, or to `F_PENDING` if acknowledge is still seen high.
- `F_OFFER` holds valid high. The synchronized rising edge of acknowledge moves it to `F_RELEASE`.
- `F_RELEASE` drops valid and asks for the next word.
  - If a strobe arrives, it goes to `F_PENDING`, or straight to `F_OFFER` if acknowledge is already low.
  - If acknowledge falls with no strobe, it goes back to `F_REQUEST`.
- `F_PENDING` holds a prefetched word. It moves to `F_OFFER` once acknowledge is low.

The slow side runs five states: `S_IDLE` → `S_LOADED` → `S_SHIFT1` → `S_SHIFT2` → `S_SHIFT3` → `S_IDLE`.
- It leaves `S_IDLE` when it captures an offered word.
- Every other transition is taken on a read strobe.
- Each read shifts the register left by one byte and fills the bottom with zeros.
- The current byte is always the top byte of the register.

Each domain has a synchronous restart that returns it to its initial state, so that a newly loaded stream can be replayed from its start.

Top module: `word_byte_unpacker`

## Requirements
- R1: After reset, `word_req` is 1, `byte_ready` is 0 and `byte_out` is 0.
- R2: Bytes of a word are delivered lowest memory byte first. For a word `w` accepted on `word_in`, the four bytes presented on `byte_out` are, in order, `w[7:0]`, `w[15:8]`, `w[23:16]` and `w[31:24]`.
- R3: Each read strobe while `byte_ready` is 1 advances to the next byte. After the fourth read, `byte_ready` is 0 at the next falling slow-clock edge.
- R4: A read strobe while `byte_ready` is 0 has no effect. The next word still starts at its byte `w[7:0]`.
- R5: Without a read strobe, `byte_out` and `byte_ready` hold their values across slow-clock cycles.
- R6: `word_strobe` is accepted only while `word_req` is 1. A strobe while `word_req` is 0 is ignored, and no word from it is ever delivered.
- R7: After a word is accepted, `word_req` stays 0 until the slow side has taken that word. It returns to 1 within five fast cycles after `byte_ready` rises, because the three-flop acknowledge synchronizer and the state update add that latency.
- R8: While the slow side is still unpacking a word, one further word can be prefetched. That word is delivered after the fourth read of the current one. Valid is held until acknowledge is seen, and it is raised again only after acknowledge has fallen.
- R9: Asserting both restarts discards any held or prefetched word. During restart `byte_ready` is 0 and `word_req` is 1. After release, only newly strobed words are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast (reader) clock |
| fast_rst_n | input | 1 | Asynchronous active-low reset, fast domain |
| fast_restart | input | 1 | Synchronous restart, fast domain |
| word_in | input | 32 | Word from the memory reader, lowest address in bits 7:0 |
| word_strobe | input | 1 | Reader presents a word this cycle |
| word_req | output | 1 | Fast side can take a word (next-fetch request) |
| slow_clk | input | 1 | Slow (consumer) clock |
| slow_rst_n | input | 1 | Asynchronous active-low reset, slow domain |
| slow_restart | input | 1 | Synchronous restart, slow domain |
| rd_strobe | input | 1 | Consumer takes the current byte |
| byte_out | output | 8 | Current byte |
| byte_ready | output | 1 | `byte_out` holds an unread byte |

## Verification
The assertions assume that the two restarts are asserted together and held for several slow cycles. This clears both handshake flags and both synchronizer chains before either side resumes. They also assume that the strobes are single-cycle pulses driven synchronously to their own clocks. The bench drives every input on the falling edge of its own clock. It offsets the slow clock's phase so that its edges never coincide with fast-clock edges, and it always holds the two restarts together for five slow cycles.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

    localparam int DEF_WORD_W = 32;
    localparam int DEF_BYTE_W = 8;

    typedef enum logic [1:0] {
        F_REQUEST,
        F_OFFER,
        F_RELEASE,
        F_PENDING
    } fast_state_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOADED,
        S_SHIFT1,
        S_SHIFT2,
        S_SHIFT3
    } slow_state_e;

endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)     chain[g] <= 1'b0;
                    else if (clear) chain[g] <= 1'b0;
                    else            chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)     chain[g] <= 1'b0;
                    else if (clear) chain[g] <= 1'b0;
                    else            chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fast_word_holder.sv
module fast_word_holder
    import unpack_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int BYTE_W     = DEF_BYTE_W,
    parameter int ACK_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_strobe,
    input  logic              ack_async,
    output logic              word_req,
    output logic              xfer_valid,
    output logic [WORD_W-1:0] xfer_word
);

    localparam int BYTES = WORD_W / BYTE_W;

    fast_state_e       state_q, state_d;
    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;
    logic              ack_lvl, ack_prev, ack_rise, accept;

    // byte reversal: lowest-address byte goes to the top
    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_swap
            assign swapped[b*BYTE_W +: BYTE_W] = word_in[(BYTES-1-b)*BYTE_W +: BYTE_W];
        end
    endgenerate

    // first ACK_STAGES-1 flops synchronize, the last one gives the edge
    level_sync #(.STAGES(ACK_STAGES-1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .d     (ack_async),
        .q     (ack_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ack_prev <= 1'b0;
        else if (restart) ack_prev <= 1'b0;
        else              ack_prev <= ack_lvl;
    end

    assign ack_rise = ack_lvl && !ack_prev;
    assign word_req = (state_q == F_REQUEST) || (state_q == F_RELEASE);
    assign accept   = word_strobe && word_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_REQUEST: if (accept)   state_d = ack_lvl ? F_PENDING : F_OFFER;
            F_OFFER:   if (ack_rise) state_d = F_RELEASE;
            F_RELEASE: begin
                if (accept)        state_d = ack_lvl ? F_PENDING : F_OFFER;
                else if (!ack_lvl) state_d = F_REQUEST;
            end
            F_PENDING: if (!ack_lvl) state_d = F_OFFER;
            default:   state_d = F_REQUEST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= F_REQUEST;
        else if (restart) state_q <= F_REQUEST;
        else              state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (restart) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= (state_d == F_OFFER);
            if (accept) word_q <= swapped;
        end
    end

    assign xfer_valid = valid_q;
    assign xfer_word  = word_q;

    assert_valid_held_R8: assert property (@(posedge clk) disable iff (!rst_n || restart)
        valid_q && !ack_rise |=> valid_q);

    assert_word_stable_R2: assert property (@(posedge clk) disable iff (!rst_n || restart)
        valid_q && !ack_rise |=> $stable(word_q));

    assert_valid_after_ack_low_R8: assert property (@(posedge clk) disable iff (!rst_n || restart)
        $rose(valid_q) |-> !ack_lvl);

    assert_no_req_while_valid_R6: assert property (@(posedge clk) disable iff (!rst_n || restart)
        valid_q |-> !word_req);

endmodule

// File: rtl/slow_byte_shifter.sv
module slow_byte_shifter
    import unpack_pkg::*;
#(
    parameter int WORD_W       = DEF_WORD_W,
    parameter int BYTE_W       = DEF_BYTE_W,
    parameter int VALID_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              valid_async,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_strobe,
    output logic              ack,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_ready
);

    slow_state_e       state_q, state_d;
    logic [WORD_W-1:0] shreg;
    logic              valid_lvl, ack_q, ready_q, capture, advance;

    level_sync #(.STAGES(VALID_STAGES)) u_valid_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .d     (valid_async),
        .q     (valid_lvl)
    );

    assign capture = (state_q == S_IDLE) && valid_lvl && !ack_q;
    assign advance = (state_q != S_IDLE) && rd_strobe;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (capture)   state_d = S_LOADED;
            S_LOADED: if (rd_strobe) state_d = S_SHIFT1;
            S_SHIFT1: if (rd_strobe) state_d = S_SHIFT2;
            S_SHIFT2: if (rd_strobe) state_d = S_SHIFT3;
            S_SHIFT3: if (rd_strobe) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= S_IDLE;
        else if (restart) state_q <= S_IDLE;
        else              state_q <= state_d;
    end

    // outputs: shifter, acknowledge, ready flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            ack_q   <= 1'b0;
            ready_q <= 1'b0;
        end else if (restart) begin
            shreg   <= '0;
            ack_q   <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            if (capture)      shreg <= word_in;
            else if (advance) shreg <= {shreg[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            if (capture)         ack_q <= 1'b1;
            else if (!valid_lvl) ack_q <= 1'b0;
            ready_q <= (state_d != S_IDLE);
        end
    end

    assign ack        = ack_q;
    assign byte_ready = ready_q;
    assign byte_out   = shreg[WORD_W-1 -: BYTE_W];

    assert_ack_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n || restart)
        $rose(ack_q) |-> (state_q == S_LOADED) && ready_q);

    assert_ack_held_R8: assert property (@(posedge clk) disable iff (!rst_n || restart)
        ack_q && valid_lvl |=> ack_q);

    assert_last_read_idles_R3: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (state_q == S_SHIFT3) && rd_strobe |=> !ready_q);

    assert_idle_read_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (state_q == S_IDLE) && !capture |=> $stable(shreg));

    assert_hold_without_read_R5: assert property (@(posedge clk) disable iff (!rst_n || restart)
        ready_q && !rd_strobe |=> ready_q && $stable(shreg));

endmodule

// File: rtl/word_byte_unpacker.sv
module word_byte_unpacker
    import unpack_pkg::*;
#(
    parameter int WORD_W       = DEF_WORD_W,
    parameter int BYTE_W       = DEF_BYTE_W,
    parameter int ACK_STAGES   = 3,
    parameter int VALID_STAGES = 2
) (
    input  logic              fast_clk,
    input  logic              fast_rst_n,
    input  logic              fast_restart,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_strobe,
    output logic              word_req,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              slow_restart,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_ready
);

    logic              xfer_valid, xfer_ack;
    logic [WORD_W-1:0] xfer_word;

    fast_word_holder #(
        .WORD_W     (WORD_W),
        .BYTE_W     (BYTE_W),
        .ACK_STAGES (ACK_STAGES)
    ) u_fast (
        .clk         (fast_clk),
        .rst_n       (fast_rst_n),
        .restart     (fast_restart),
        .word_in     (word_in),
        .word_strobe (word_strobe),
        .ack_async   (xfer_ack),
        .word_req    (word_req),
        .xfer_valid  (xfer_valid),
        .xfer_word   (xfer_word)
    );

    slow_byte_shifter #(
        .WORD_W       (WORD_W),
        .BYTE_W       (BYTE_W),
        .VALID_STAGES (VALID_STAGES)
    ) u_slow (
        .clk         (slow_clk),
        .rst_n       (slow_rst_n),
        .restart     (slow_restart),
        .valid_async (xfer_valid),
        .word_in     (xfer_word),
        .rd_strobe   (rd_strobe),
        .ack         (xfer_ack),
        .byte_out    (byte_out),
        .byte_ready  (byte_ready)
    );

endmodule

// File: tb/word_byte_unpacker_test.sv
module word_byte_unpacker_test;

    localparam int FAST_PERIOD = 10;
    localparam int SLOW_PERIOD = 1000;
    localparam int WATCHDOG    = 190000;
    localparam int SWEEP_WORDS = 24;

    logic        fast_clk = 1'b0, slow_clk = 1'b0;
    logic        fast_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        fast_restart = 1'b0, slow_restart = 1'b0;
    logic [31:0] word_in = '0;
    logic        word_strobe = 1'b0, rd_strobe = 1'b0;
    logic        word_req, byte_ready;
    logic [7:0]  byte_out;

    int n_checks = 0, n_fail = 0, fast_cycles = 0;

    word_byte_unpacker uut (
        .fast_clk(fast_clk), .fast_rst_n(fast_rst_n), .fast_restart(fast_restart),
        .word_in(word_in), .word_strobe(word_strobe), .word_req(word_req),
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .slow_restart(slow_restart),
        .rd_strobe(rd_strobe), .byte_out(byte_out), .byte_ready(byte_ready)
    );

    always #(FAST_PERIOD/2) fast_clk = ~fast_clk;
    initial begin
        #3;
        forever #(SLOW_PERIOD/2) slow_clk = ~slow_clk;
    end

    always @(posedge fast_clk) begin
        fast_cycles++;
        if (fast_cycles == WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", fast_cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int k);
        logic [31:0] w;
        if (k == 0) return 32'h0000_0000;
        if (k == 1) return 32'hFFFF_FFFF;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'((k * 37 + i * 91 + 5) & 255);
        return w;
    endfunction

    task automatic push_word(input logic [31:0] w);
        @(negedge fast_clk);
        while (!word_req) @(negedge fast_clk);
        word_in     = w;
        word_strobe = 1'b1;
        @(negedge fast_clk);
        word_strobe = 1'b0;
    endtask

    task automatic pull_word(input logic [31:0] w, input int gap, input string tag);
        int waited = 0;
        logic [7:0] seen;
        @(negedge slow_clk);
        while (!byte_ready && waited < 60) begin
            @(negedge slow_clk);
            waited++;
        end
        check(byte_ready === 1'b1, tag, "word arrival", 32'(byte_ready), 32'd1);
        for (int i = 0; i < 4; i++) begin
            check(byte_out === w[8*i +: 8], tag, "R2 byte order", 32'(byte_out), 32'(w[8*i +: 8]));
            seen = byte_out;
            if (gap > 0) begin
                repeat (gap) @(negedge slow_clk);
                check(byte_out === seen && byte_ready === 1'b1, tag, "R5 hold without read",
                      32'(byte_out), 32'(seen));
            end
            rd_strobe = 1'b1;
            @(negedge slow_clk);
            rd_strobe = 1'b0;
        end
        check(byte_ready === 1'b0, tag, "R3 ready drops after fourth read", 32'(byte_ready), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge slow_clk);
        // R1 reset state
        check(word_req === 1'b1, "R1", "word_req in reset", 32'(word_req), 32'd1);
        check(byte_ready === 1'b0, "R1", "byte_ready in reset", 32'(byte_ready), 32'd0);
        check(byte_out === 8'h00, "R1", "byte_out in reset", 32'(byte_out), 32'd0);
        fast_rst_n = 1'b1;
        slow_rst_n = 1'b1;
        repeat (2) @(negedge slow_clk);
        check(word_req === 1'b1 && byte_ready === 1'b0, "R1", "after reset release",
              {30'd0, word_req, byte_ready}, 32'd2);

        // R4: reads while idle are ignored
        rd_strobe = 1'b1;
        repeat (3) @(negedge slow_clk);
        rd_strobe = 1'b0;
        check(byte_ready === 1'b0, "R4", "idle reads leave ready low", 32'(byte_ready), 32'd0);
        push_word(32'hA1B2_C3D4);
        pull_word(32'hA1B2_C3D4, 0, "R4");

        // R6 / R7: strobe while busy ignored, request returns after take-over
        push_word(32'h1122_3344);
        check(word_req === 1'b0, "R7", "request low after accept", 32'(word_req), 32'd0);
        word_in     = 32'hDEAD_BEEF;
        word_strobe = 1'b1;
        @(negedge fast_clk);
        word_strobe = 1'b0;
        begin
            int t = 0;
            while (!byte_ready && t < 20000) begin
                @(negedge fast_clk);
                t++;
            end
        end
        check(word_req === 1'b0, "R7", "request still low as word lands", 32'(word_req), 32'd0);
        repeat (5) @(negedge fast_clk);
        check(word_req === 1'b1, "R7", "request back after ack edge", 32'(word_req), 32'd1);
        pull_word(32'h1122_3344, 2, "R6");
        repeat (15) @(negedge slow_clk);
        check(byte_ready === 1'b0, "R6", "ignored strobe never delivered", 32'(byte_ready), 32'd0);

        // R8: sweep with prefetch, producer and consumer concurrent
        fork
            begin
                for (int k = 0; k < SWEEP_WORDS; k++) push_word(pattern(k));
            end
            begin
                for (int k = 0; k < SWEEP_WORDS; k++) pull_word(pattern(k), k % 3, "R8");
            end
        join

        // R9: restart discards held and prefetched words
        push_word(32'h0F1E_2D3C);
        begin
            int t = 0;
            while (!byte_ready && t < 60) begin
                @(negedge slow_clk);
                t++;
            end
        end
        push_word(32'h5566_7788);
        @(negedge slow_clk);
        rd_strobe = 1'b1;
        @(negedge slow_clk);
        rd_strobe = 1'b0;
        fast_restart = 1'b1;
        slow_restart = 1'b1;
        repeat (5) @(negedge slow_clk);
        check(byte_ready === 1'b0, "R9", "ready low in restart", 32'(byte_ready), 32'd0);
        check(word_req === 1'b1, "R9", "request high in restart", 32'(word_req), 32'd1);
        fast_restart = 1'b0;
        slow_restart = 1'b0;
        repeat (10) @(negedge slow_clk);
        check(byte_ready === 1'b0, "R9", "prefetched word discarded", 32'(byte_ready), 32'd0);
        push_word(32'h9ABC_DEF0);
        pull_word(32'h9ABC_DEF0, 1, "R9");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule